// File: doc/BRIEF.md
# Vertical Sync Re-timer with Field Detection

This block cleans up a raw vertical sync and re-times it against a clean horizontal sync. It counts reference clocks between consecutive Hsync leading edges to learn the line length. When a raw Vsync leading edge arrives, the block takes its offset within the line, subtracts a programmable separator threshold, and sorts the edge into one of four equal quarters of the line. The quarter decides the interlace field. It also decides where the regenerated Vsync starts in the following line: on the Hsync edge for field 0, or at mid-line for field 1.

A spacing counter discards Vsync edges that come too close to the last accepted one. A duration stage sets the length of the output pulse. It either copies the input pulse length in clocks, or it lasts a programmed number of lines. When the filter is switched off, the raw Vsync goes straight to the output. Register values arrive as plain inputs.

The controller has four states. `S_IDLE` waits for an edge. `S_WAIT_EDGE` waits for the next Hsync edge. `S_WAIT_MID` waits for the mid-line point. `S_ACTIVE` drives the pulse. The transitions are:
- accept: `S_IDLE` to `S_WAIT_EDGE`, on a rising Vsync with the spacing satisfied.
- edge-to-active: `S_WAIT_EDGE` to `S_ACTIVE`, on an Hsync edge when the field is 0.
- edge-to-mid: `S_WAIT_EDGE` to `S_WAIT_MID`, on an Hsync edge when the field is 1.
- mid-to-active: `S_WAIT_MID` to `S_ACTIVE`, on the mid-line tick.
- end-of-pulse: `S_ACTIVE` to `S_IDLE`.
- disable: any state to `S_IDLE` while the filter is off.

Top module: `vsync_field_filter`

## Requirements
- R1: While reset is asserted and after it is released, `vsync_o` and `field_o` are 0 until a Vsync is accepted.
- R2: With `filt_en_i` = 0, `vsync_o` equals `vsync_i` in the same cycle, `field_o` is 0, and the controller rests in `S_IDLE`.
- R3: The line length L is the clock count between consecutive Hsync leading edges, and offset 0 is the edge cycle. Take rel = (offset − threshold) mod L. Quarter 1 is rel < L/4, quarter 2 is rel < L/2, quarter 3 is rel < 3L/4, and quarter 4 is the rest. Quarters 2 and 3 give field 1; quarters 1 and 4 give field 0.
- R4: For field 0, `vsync_o` rises in the cycle after the first Hsync leading edge that follows the accepted Vsync edge.
- R5: For field 1, `vsync_o` rises in the cycle after the mid-line point (offset L/2) of the line that begins at that first Hsync edge.
- R6: `field_o` changes only in the cycle in which `vsync_o` rises. It holds its value after the pulse until the next accepted Vsync.
- R7: A Vsync edge is accepted only when at least MIN_GAP (64) Hsync leading edges have occurred since the last accepted edge. It must also arrive in `S_IDLE`. Any other edge is ignored and produces no pulse.
- R8: With `dur_en_i` = 0, the output pulse lasts exactly as many clocks as the input Vsync was high.
- R9: With `dur_en_i` = 1, the output pulse lasts `dur_lines_i` × L clocks, ending on the same kind of line event that started it. A value of 0 counts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Clean horizontal sync, active high |
| vsync_i | input | 1 | Raw vertical sync, active high |
| filt_en_i | input | 1 | 1 enables re-timing; 0 passes `vsync_i` through |
| dur_en_i | input | 1 | 1 sets the pulse length from `dur_lines_i` |
| dur_lines_i | input | DURW | Output pulse length in lines |
| sep_thresh_i | input | CW | Separator threshold subtracted from the offset |
| vsync_o | output | 1 | Regenerated vertical sync |
| field_o | output | 1 | Interlace field, 1 for quarters 2 and 3 |

## Verification
The bench builds the block with its default parameters: CW = 12, DW = 16, DURW = 8 and MIN_GAP = 64. It drives 40-clock lines with a threshold of 4. This puts the quarter boundaries at offsets 14 and 34, so single-offset steps test both sides of each boundary. At that line length the 64-line spacing rule is reached within a few thousand cycles. A rejected edge at 63 lines and an accepted edge at 64 lines can therefore both be tried directly.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_EDGE,
        S_WAIT_MID,
        S_ACTIVE
    } vsf_state_e;
endpackage

// File: rtl/vsf_line_meter.sv
module vsf_line_meter #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_i,
    output logic          hs_rise_o,
    output logic          mid_tick_o,
    output logic [CW-1:0] off_o,
    output logic [CW-1:0] len_o
);
    localparam logic [CW-1:0] POS_MAX = '1;

    logic          hs_q;
    logic          seen_q;
    logic [CW-1:0] pos_q;
    logic [CW-1:0] len_q;

    assign hs_rise_o  = hsync_i & ~hs_q;
    assign off_o      = hs_rise_o ? '0 : pos_q + 1'b1;
    assign len_o      = len_q;
    assign mid_tick_o = (len_q != '0) && !hs_rise_o && (off_o == (len_q >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q   <= 1'b0;
            seen_q <= 1'b0;
            pos_q  <= '0;
            len_q  <= '0;
        end else begin
            hs_q <= hsync_i;
            if (hs_rise_o) begin
                pos_q  <= '0;
                seen_q <= 1'b1;
                if (seen_q) len_q <= pos_q + 1'b1;
            end else if (pos_q != POS_MAX) begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vsf_gap_counter.sv
module vsf_gap_counter #(
    parameter int MIN_GAP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_rise_i,
    input  logic accept_i,
    output logic gap_ok_o
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(MIN_GAP);

    logic [GW-1:0] gap_q;

    assign gap_ok_o = (gap_q >= GAP_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_FULL;
        end else if (accept_i) begin
            gap_q <= '0;
        end else if (hs_rise_i && gap_q < GAP_FULL) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_FULL); // R7
endmodule

// File: rtl/vsf_span_meter.sv
module vsf_span_meter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          vsync_i,
    output logic          run_o,
    output logic [DW-1:0] len_o
);
    localparam logic [DW-1:0] LEN_MAX = '1;

    logic          run_q;
    logic [DW-1:0] len_q;

    assign run_o = run_q;
    assign len_o = len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            len_q <= '0;
        end else if (start_i) begin
            run_q <= 1'b1;
            len_q <= DW'(1);
        end else if (run_q) begin
            if (!vsync_i)              run_q <= 1'b0;
            else if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
        end
    end

    AST_SPAN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (len_q != '0)); // R8
endmodule

// File: rtl/vsync_field_filter.sv
module vsync_field_filter
    import vsf_pkg::*;
#(
    parameter int CW      = 12,
    parameter int DW      = 16,
    parameter int DURW    = 8,
    parameter int MIN_GAP = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hsync_i,
    input  logic            vsync_i,
    input  logic            filt_en_i,
    input  logic            dur_en_i,
    input  logic [DURW-1:0] dur_lines_i,
    input  logic [CW-1:0]   sep_thresh_i,
    output logic            vsync_o,
    output logic            field_o
);
    localparam logic [DW-1:0] OUT_MAX = '1;

    function automatic logic odd_field(input logic [CW-1:0] off,
                                       input logic [CW-1:0] thr,
                                       input logic [CW-1:0] len);
        logic [CW:0] rel, qtr, half, three;
        rel   = (off >= thr) ? ({1'b0, off} - {1'b0, thr})
                             : ({1'b0, off} + {1'b0, len} - {1'b0, thr});
        qtr   = {1'b0, len} >> 2;
        half  = {1'b0, len} >> 1;
        three = half + qtr;
        return (rel >= qtr) && (rel < three);
    endfunction

    logic            hs_rise, mid_tick;
    logic [CW-1:0]   off, line_len;
    logic            gap_ok, in_run;
    logic [DW-1:0]   in_len;
    logic            vs_q, vs_rise, accept;
    logic            line_evt, pulse_end;
    vsf_state_e      state_q, state_d;
    logic            vs_r, field_r, pend_q;
    logic [DW-1:0]   out_cnt;
    logic [DURW-1:0] line_cnt;

    vsf_line_meter #(.CW(CW)) u_line (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i),
        .hs_rise_o(hs_rise), .mid_tick_o(mid_tick), .off_o(off), .len_o(line_len)
    );

    vsf_gap_counter #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .hs_rise_i(hs_rise), .accept_i(accept), .gap_ok_o(gap_ok)
    );

    vsf_span_meter #(.DW(DW)) u_span (
        .clk(clk), .rst_n(rst_n), .start_i(accept), .vsync_i(vsync_i),
        .run_o(in_run), .len_o(in_len)
    );

    assign vs_rise   = vsync_i & ~vs_q;
    assign accept    = filt_en_i && (state_q == S_IDLE) && vs_rise && gap_ok;
    assign line_evt  = field_r ? mid_tick : hs_rise;
    assign pulse_end = dur_en_i
        ? (line_evt && ({1'b0, line_cnt} + 1'b1 >= {1'b0, dur_lines_i}))
        : (!in_run && out_cnt >= in_len);

    always_comb begin
        state_d = state_q;
        if (!filt_en_i) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:      if (accept)    state_d = S_WAIT_EDGE;
                S_WAIT_EDGE: if (hs_rise)   state_d = pend_q ? S_WAIT_MID : S_ACTIVE;
                S_WAIT_MID:  if (mid_tick)  state_d = S_ACTIVE;
                S_ACTIVE:    if (pulse_end) state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            vs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            vs_q    <= vsync_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_r     <= 1'b0;
            field_r  <= 1'b0;
            pend_q   <= 1'b0;
            out_cnt  <= '0;
            line_cnt <= '0;
        end else begin
            if (accept) pend_q <= odd_field(off, sep_thresh_i, line_len);
            if (state_q != S_ACTIVE && state_d == S_ACTIVE) begin
                vs_r     <= 1'b1;
                field_r  <= pend_q;
                out_cnt  <= DW'(1);
                line_cnt <= '0;
            end else if (state_q == S_ACTIVE) begin
                if (state_d != S_ACTIVE) begin
                    vs_r <= 1'b0;
                end else begin
                    if (out_cnt != OUT_MAX) out_cnt <= out_cnt + 1'b1;
                    if (line_evt)           line_cnt <= line_cnt + 1'b1;
                end
            end
        end
    end

    assign vsync_o = filt_en_i ? vs_r : vsync_i;
    assign field_o = filt_en_i & field_r;

    AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en_i |=> (state_q == S_IDLE)); // R2
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_r) |-> $rose(vs_r)); // R6
    AST_F0_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vs_r) && !field_r) |-> $past(hs_rise)); // R4
    AST_F1_ON_MID: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vs_r) && field_r) |-> $past(mid_tick)); // R5
    AST_GAP_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && filt_en_i && vs_rise && !gap_ok) |=> (state_q == S_IDLE)); // R7
endmodule

// File: tb/vsync_field_filter_tb.sv
module vsync_field_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P  = 40;
    localparam int HW = 4;
    localparam int NROWS = 8;

    typedef struct packed {
        int off;
        int vlen;
        bit den;
        int dur;
        bit fld;
    } row_t;

    // offset, input length, duration enable, lines, expected field (R3)
    localparam row_t ROWS [NROWS] = '{
        '{5,  100, 1'b0, 0, 1'b0},
        '{14, 100, 1'b0, 0, 1'b1},
        '{33, 120, 1'b0, 0, 1'b1},
        '{34, 80,  1'b0, 0, 1'b0},
        '{2,  60,  1'b1, 4, 1'b0},
        '{0,  70,  1'b0, 0, 1'b0},
        '{13, 60,  1'b1, 0, 1'b0},
        '{25, 60,  1'b1, 3, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic       filt_en = 1'b1;
    logic       dur_en = 1'b0;
    logic [7:0] dur_lines = 8'd4;
    logic [11:0] thresh = 12'd4;
    logic       vs_o, fld_o;

    int cyc = 0;
    int wd = 0;
    int checks = 0;
    int fails = 0;
    int rise_cnt = 0, fall_cnt = 0;
    int last_rise = 0, last_fall = 0;
    logic last_fld = 1'b0;
    logic vs_prev = 1'b0;

    vsync_field_filter dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .filt_en_i(filt_en), .dur_en_i(dur_en), .dur_lines_i(dur_lines),
        .sep_thresh_i(thresh), .vsync_o(vs_o), .field_o(fld_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) hsync <= ((cyc % P) < HW);

    always @(negedge clk) begin
        if (vs_o && !vs_prev) begin
            rise_cnt  <= rise_cnt + 1;
            last_rise <= cyc;
            last_fld  <= fld_o;
        end
        if (!vs_o && vs_prev) begin
            fall_cnt  <= fall_cnt + 1;
            last_fall <= cyc;
        end
        vs_prev <= vs_o;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", wd);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire(input int off, input int vlen, output int v);
        repeat (66 * P) @(negedge clk);
        while ((cyc % P) != off) @(negedge clk);
        vsync = 1'b1;
        v = cyc;
        repeat (vlen) @(negedge clk);
        vsync = 1'b0;
    endtask

    initial begin
        int v, base_f, exp_start, exp_len, base_r;
        repeat (5) @(negedge clk);
        check("R1 vsync_o in reset", int'(vs_o), 0);
        check("R1 field_o in reset", int'(fld_o), 0);
        rst_n = 1'b1;
        repeat (3 * P) @(negedge clk);
        check("R1 vsync_o after reset", int'(vs_o), 0);
        check("R1 field_o after reset", int'(fld_o), 0);

        for (int i = 0; i < NROWS; i++) begin
            @(negedge clk);
            dur_en    = ROWS[i].den;
            dur_lines = 8'(ROWS[i].dur);
            @(posedge clk);
            base_f = fall_cnt;
            fire(ROWS[i].off, ROWS[i].vlen, v);
            @(posedge clk);
            while (fall_cnt == base_f) @(posedge clk);
            exp_start = v - ROWS[i].off + P + 1 + (ROWS[i].fld ? P / 2 : 0);
            if (ROWS[i].den) exp_len = ((ROWS[i].dur < 1) ? 1 : ROWS[i].dur) * P;
            else             exp_len = ROWS[i].vlen;
            check("R3 field at pulse start", int'(last_fld), int'(ROWS[i].fld));
            check(ROWS[i].fld ? "R5 mid-line start" : "R4 edge start", last_rise, exp_start);
            check(ROWS[i].den ? "R9 line duration" : "R8 copied duration", last_fall - last_rise, exp_len);
            repeat (3) @(negedge clk);
            check("R6 field held after pulse", int'(fld_o), int'(ROWS[i].fld));
        end

        // R2: pass-through when disabled; field forced low although last field was 1
        @(negedge clk);
        filt_en = 1'b0;
        vsync = 1'b1;
        #1;
        check("R2 pass-through high", int'(vs_o), 1);
        check("R2 field masked", int'(fld_o), 0);
        @(negedge clk);
        vsync = 1'b0;
        #1;
        check("R2 pass-through low", int'(vs_o), 0);
        repeat (4) @(negedge clk);
        filt_en = 1'b1;
        dur_en = 1'b0;

        // R7: spacing rule, 63 lines rejected, 64 lines accepted
        @(posedge clk);
        base_f = fall_cnt;
        fire(5, 100, v);
        @(posedge clk);
        while (fall_cnt == base_f) @(posedge clk);
        base_r = rise_cnt;
        while (cyc != v + 63 * P) @(negedge clk);
        vsync = 1'b1;
        repeat (10) @(negedge clk);
        vsync = 1'b0;
        while (cyc != v + 64 * P) @(negedge clk);
        @(posedge clk);
        check("R7 early edge ignored", rise_cnt, base_r);
        @(negedge clk);
        while (cyc != v + 64 * P + 1) @(negedge clk);
        vsync = 1'b1;
        base_f = fall_cnt;
        repeat (100) @(negedge clk);
        vsync = 1'b0;
        @(posedge clk);
        while (fall_cnt == base_f) @(posedge clk);
        check("R7 edge after 64 lines accepted", last_rise, v + 64 * P + 1 - 6 + P + 1);
        check("R8 length after spacing", last_fall - last_rise, 100);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule